// File: doc/BRIEF.md
# I2C Target with Byte-Level Clock Stretching

This block is a 7-bit-address target for a two-wire I2C bus. It sits beside a small peripheral. It oversamples the open-drain clock and data lines with a fast system clock. From those samples it recognises START and STOP conditions and collects the address byte. It answers only when the address matches its own. After a write address, each data byte it receives is offered to local logic on a valid/ready pair. After a read address, it asks local logic for each byte it must send.

Each byte boundary is a point where the target can throttle the controller. It keeps the clock line low until the local handshake for that byte has completed. A slow consumer or producer therefore sets the pace of the bus, and no data is lost or invented. Both bus outputs are pull-down enables: a 1 pulls the line low and a 0 releases it. The bus itself supplies the high level through its pull-ups.

Top module: `i2c_tgt_stretch`

## Requirements
- R1: A fall of SDA while SCL is high is a START and begins address reception. A rise of SDA while SCL is high is a STOP, which returns the target to idle with both pull-downs released. Neither condition needs the target to be addressed.
- R2: The first byte after a START carries the address in bits 7..1, sent MSB first, and the direction flag in bit 0 (1 = read, 0 = write). When bits 7..1 equal `own_addr_i`, the target pulls SDA low during the ninth clock and releases it after that clock falls.
- R3: On an address mismatch the target leaves SDA released. It raises neither `rx_valid_o` nor `tx_ready_o` and ignores all clocks until the next START or STOP.
- R4: In a write, each received byte appears on `rx_data_o`, MSB first, with `rx_valid_o` high after its eighth bit. Once the handshake completes, the target acknowledges the byte with SDA low during the ninth clock.
- R5: In a write, SCL is pulled low from the fall that ends the eighth bit until the cycle after `rx_valid_o && rx_ready_i`. While the target waits, `rx_data_o` stays stable.
- R6: In a read, `tx_ready_o` rises with SCL held low, both after the address acknowledge and after each controller ACK (SDA low on the ninth clock). The byte taken on `tx_valid_i` is shifted out MSB first, and SCL is released only after the first bit is on SDA.
- R7: A controller NACK (SDA high on the ninth clock) ends the read. The target keeps SDA released and asks for no further byte until the next START.
- R8: A START seen at any point, including inside a transfer or after a mismatch, restarts address reception without an intervening STOP.
- R9: The target changes its SDA pull-down only while SCL is low.
- R10: During and after reset, both pull-downs are released and `rx_valid_o` and `tx_ready_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| own_addr_i | input | 7 | Address the target answers to; held stable while the bus is idle |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| scl_pull_o | output | 1 | 1 pulls SCL low (stretch) |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge or data zero) |
| rx_data_o | output | 8 | Byte received in a write |
| rx_valid_o | output | 1 | `rx_data_o` holds a new byte |
| rx_ready_i | input | 1 | Local logic takes the byte |
| tx_data_i | input | 8 | Byte to send in a read |
| tx_valid_i | input | 1 | `tx_data_i` is valid |
| tx_ready_o | output | 1 | Target requests the next byte to send |

## Verification
The hardest state to reach is a byte boundary where the controller has already released SCL while the target still holds it low. The acknowledge or first data bit must then be placed on SDA before the line is allowed to rise. The bench models both lines as wired-AND buses and drives them from a controller that waits for SCL to read high. Its local responders wait a programmable number of cycles before each handshake, so the stretch lasts long and measurably. Repeated STARTs are issued straight after a mismatched address and in the middle of a write, and a STOP is issued partway through a data byte. These cover restart and abort paths that a plain sequence of transfers never visits.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = BYTE_W - 1;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SKIP,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BIT,
    ST_WR_HOLD,
    ST_WR_ACK_SU,
    ST_WR_ACK,
    ST_RD_FETCH,
    ST_RD_SU,
    ST_RD_BIT,
    ST_RD_ACK
  } tgt_state_e;

  typedef enum logic [1:0] {
    SH_HOLD,
    SH_IN,
    SH_LOAD,
    SH_LEFT
  } shift_op_e;

endpackage

// File: rtl/i2c_tgt_rst_sync.sv
module i2c_tgt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/i2c_tgt_line_sync.sv
module i2c_tgt_line_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [WIDTH-1:0] src;
      if (g == 0) begin : g_first
        assign src = d_i;
      end else begin : g_next
        assign src = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[g] <= '1;
        end else begin
          stage_q[g] <= src;
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);

  logic scl_d_q;
  logic sda_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d_q <= 1'b1;
      sda_d_q <= 1'b1;
    end else begin
      scl_d_q <= scl_s;
      sda_d_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d_q;
  assign scl_fall  = ~scl_s & scl_d_q;
  assign bus_start = scl_s & scl_d_q & sda_d_q & ~sda_s;
  assign bus_stop  = scl_s & scl_d_q & ~sda_d_q & sda_s;

endmodule

// File: rtl/i2c_tgt_shreg.sv
module i2c_tgt_shreg
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  shift_op_e         op_i,
  input  logic              bit_i,
  input  logic [BYTE_W-1:0] load_i,
  output logic [BYTE_W-1:0] data_o
);

  logic [BYTE_W-1:0] data_q;
  logic [BYTE_W-1:0] data_n;
  logic              data_en;

  always_comb begin
    data_en = 1'b1;
    data_n  = data_q;
    unique case (op_i)
      SH_IN:   data_n = {data_q[BYTE_W-2:0], bit_i};
      SH_LOAD: data_n = load_i;
      SH_LEFT: data_n = {data_q[BYTE_W-2:0], 1'b0};
      default: data_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_n;
    end
  end

  assign data_o = data_q;

endmodule

// File: rtl/i2c_tgt_stretch.sv
module i2c_tgt_stretch
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull_o,
  output logic              sda_pull_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  logic rst_sync_n;
  logic [1:0] line_s;
  logic scl_s;
  logic sda_s;
  logic scl_rise;
  logic scl_fall;
  logic bus_start;
  logic bus_stop;

  tgt_state_e        state_q, state_n;
  logic              sda_q, sda_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              rw_q, rw_n;
  logic              nack_q, nack_n;
  shift_op_e         sh_op;
  logic [BYTE_W-1:0] sh_data;

  i2c_tgt_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  i2c_tgt_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );

  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  i2c_tgt_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop)
  );

  i2c_tgt_shreg u_shreg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .op_i   (sh_op),
    .bit_i  (sda_s),
    .load_i (tx_data_i),
    .data_o (sh_data)
  );

  // next-state logic
  always_comb begin
    state_n = state_q;
    sda_n   = sda_q;
    cnt_n   = cnt_q;
    rw_n    = rw_q;
    nack_n  = nack_q;
    sh_op   = SH_HOLD;
    if (bus_stop) begin
      state_n = ST_IDLE;
      sda_n   = 1'b0;
    end else if (bus_start) begin
      state_n = ST_ADDR;
      sda_n   = 1'b0;
      cnt_n   = '0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_op = SH_IN;
            cnt_n = cnt_q + CNT_W'(1);
          end else if (scl_fall && cnt_q == LAST_BIT) begin
            if (sh_data[BYTE_W-1:1] == own_addr_i) begin
              rw_n    = sh_data[0];
              sda_n   = 1'b1;
              state_n = ST_ADDR_ACK;
            end else begin
              state_n = ST_SKIP;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            sda_n   = 1'b0;
            cnt_n   = '0;
            state_n = rw_q ? ST_RD_FETCH : ST_WR_BIT;
          end
        end
        ST_WR_BIT: begin
          if (scl_rise) begin
            sh_op = SH_IN;
            cnt_n = cnt_q + CNT_W'(1);
          end else if (scl_fall && cnt_q == LAST_BIT) begin
            state_n = ST_WR_HOLD;
          end
        end
        ST_WR_HOLD: begin
          if (rx_ready_i) begin
            sda_n   = 1'b1;
            state_n = ST_WR_ACK_SU;
          end
        end
        ST_WR_ACK_SU: state_n = ST_WR_ACK;
        ST_WR_ACK: begin
          if (scl_fall) begin
            sda_n   = 1'b0;
            cnt_n   = '0;
            state_n = ST_WR_BIT;
          end
        end
        ST_RD_FETCH: begin
          if (tx_valid_i) begin
            sh_op   = SH_LOAD;
            sda_n   = ~tx_data_i[BYTE_W-1];
            cnt_n   = '0;
            state_n = ST_RD_SU;
          end
        end
        ST_RD_SU: state_n = ST_RD_BIT;
        ST_RD_BIT: begin
          if (scl_rise) begin
            cnt_n = cnt_q + CNT_W'(1);
          end else if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              sda_n   = 1'b0;
              state_n = ST_RD_ACK;
            end else begin
              sh_op = SH_LEFT;
              sda_n = ~sh_data[BYTE_W-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            nack_n = sda_s;
          end else if (scl_fall) begin
            state_n = nack_q ? ST_SKIP : ST_RD_FETCH;
          end
        end
        default: ;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      sda_q   <= 1'b0;
      cnt_q   <= '0;
      rw_q    <= 1'b0;
      nack_q  <= 1'b1;
    end else begin
      state_q <= state_n;
      sda_q   <= sda_n;
      cnt_q   <= cnt_n;
      rw_q    <= rw_n;
      nack_q  <= nack_n;
    end
  end

  assign scl_pull_o = (state_q == ST_WR_HOLD)  || (state_q == ST_WR_ACK_SU) ||
                      (state_q == ST_RD_FETCH) || (state_q == ST_RD_SU);
  assign sda_pull_o = sda_q;
  assign rx_data_o  = sh_data;
  assign rx_valid_o = (state_q == ST_WR_HOLD);
  assign tx_ready_o = (state_q == ST_RD_FETCH);

endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       scl_pull_o,
  input logic       sda_pull_o,
  input logic [7:0] rx_data_o,
  input logic       rx_valid_o,
  input logic       rx_ready_i,
  input logic       tx_ready_o
);

  // R5: a pending byte keeps the clock stretched
  a_r5_hold_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> scl_pull_o);

  // R5: offered byte stays put until taken
  a_r5_rx_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));

  // R4: a byte is offered only after the clock has gone low
  a_r4_valid_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid_o) |-> !scl_s);

  // R6: a byte request keeps the clock stretched
  a_r6_fetch_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready_o |-> scl_pull_o);

  // R9: data pull-down moves only on decisions taken while SCL was low
  a_r9_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) |-> !$past(scl_s));

endmodule

bind i2c_tgt_stretch i2c_tgt_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .scl_s      (scl_s),
  .scl_pull_o (scl_pull_o),
  .sda_pull_o (sda_pull_o),
  .rx_data_o  (rx_data_o),
  .rx_valid_o (rx_valid_o),
  .rx_ready_i (rx_ready_i),
  .tx_ready_o (tx_ready_o)
);

// File: tb/test_i2c_tgt_stretch.sv
module test_i2c_tgt_stretch;

  localparam int Q = 12;
  localparam logic [6:0] OWN = 7'h3A;

  typedef struct packed {
    logic       rw;
    logic [6:0] addr;
    logic [7:0] data;
    logic       hit;
    logic [7:0] dly;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 7'h3A, 8'hA5, 1'b1, 8'd0},
    '{1'b0, 7'h3B, 8'h11, 1'b0, 8'd0},
    '{1'b1, 7'h3A, 8'hC3, 1'b1, 8'd30},
    '{1'b0, 7'h3A, 8'h00, 1'b1, 8'd40},
    '{1'b1, 7'h3A, 8'h7E, 1'b1, 8'd0},
    '{1'b1, 7'h25, 8'h99, 1'b0, 8'd3},
    '{1'b0, 7'h3A, 8'hFF, 1'b1, 8'd5},
    '{1'b1, 7'h3A, 8'h81, 1'b1, 8'd12}
  };

  logic clk;
  logic rst_n;
  logic scl_ctl, sda_ctl;
  logic scl_line, sda_line;
  logic scl_pull_o, sda_pull_o;
  logic [7:0] rx_data_o;
  logic rx_valid_o, rx_ready_i;
  logic [7:0] tx_data_i;
  logic tx_valid_i, tx_ready_o;

  int n_chk, n_fail;
  int rx_dly, tx_dly;
  int rx_n, tx_n;
  int pull_cnt, sda_viol;
  logic [7:0] rx_log [64];
  logic [7:0] tx_mem [64];
  logic prev_sda;

  assign scl_line = scl_ctl & ~scl_pull_o;
  assign sda_line = sda_ctl & ~sda_pull_o;

  i2c_tgt_stretch i_i2c_tgt_stretch (
    .clk        (clk),
    .rst_n      (rst_n),
    .own_addr_i (OWN),
    .scl_i      (scl_line),
    .sda_i      (sda_line),
    .scl_pull_o (scl_pull_o),
    .sda_pull_o (sda_pull_o),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o),
    .rx_ready_i (rx_ready_i),
    .tx_data_i  (tx_data_i),
    .tx_valid_i (tx_valid_i),
    .tx_ready_o (tx_ready_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  // local consumer of written bytes
  initial begin
    rx_ready_i = 1'b0;
    forever begin
      @(negedge clk);
      if (rx_valid_o) begin
        repeat (rx_dly) @(negedge clk);
        rx_ready_i = 1'b1;
        rx_log[rx_n[5:0]] = rx_data_o;
        @(negedge clk);
        rx_ready_i = 1'b0;
        rx_n++;
      end
    end
  end

  // local producer of read bytes
  initial begin
    tx_valid_i = 1'b0;
    tx_data_i  = 8'h00;
    forever begin
      @(negedge clk);
      if (tx_ready_o) begin
        repeat (tx_dly) @(negedge clk);
        tx_valid_i = 1'b1;
        tx_data_i  = tx_mem[tx_n[5:0]];
        @(negedge clk);
        tx_valid_i = 1'b0;
        tx_n++;
      end
    end
  end

  // stretch length and SDA-change monitor
  initial begin
    prev_sda = 1'b0;
    forever begin
      @(negedge clk);
      if (scl_pull_o) pull_cnt++;
      if (rst_n && sda_pull_o !== prev_sda && scl_line) sda_viol++;
      prev_sda = sda_pull_o;
    end
  end

  // controller side
  task automatic scl_up();
    scl_ctl = 1'b1;
    @(negedge clk);
    while (!scl_line) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sda_ctl = b;
    wt(Q);
    scl_up();
    wt(Q);
    scl_ctl = 1'b0;
    wt(Q);
  endtask

  task automatic recv_bit(output logic b);
    sda_ctl = 1'b1;
    wt(Q);
    scl_up();
    wt(Q / 2);
    b = sda_line;
    wt(Q / 2);
    scl_ctl = 1'b0;
    wt(Q);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack_bit);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(ack_bit);
  endtask

  task automatic rd_byte(output logic [7:0] d, input logic nack);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      recv_bit(b);
      d[i] = b;
    end
    send_bit(nack);
  endtask

  task automatic bus_start();
    sda_ctl = 1'b1;
    scl_ctl = 1'b1;
    wt(Q);
    sda_ctl = 1'b0;
    wt(Q);
    scl_ctl = 1'b0;
    wt(Q);
  endtask

  task automatic bus_rstart();
    sda_ctl = 1'b1;
    wt(Q);
    scl_up();
    wt(Q);
    sda_ctl = 1'b0;
    wt(Q);
    scl_ctl = 1'b0;
    wt(Q);
  endtask

  task automatic bus_stop();
    sda_ctl = 1'b0;
    wt(Q);
    scl_up();
    wt(Q);
    sda_ctl = 1'b1;
    wt(Q);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic       a, a2, b;
    logic [7:0] d;
    vec_t       v;
    int         rx0, tx0;
    n_chk = 0; n_fail = 0; rx_n = 0; tx_n = 0;
    pull_cnt = 0; sda_viol = 0; rx_dly = 0; tx_dly = 0;
    scl_ctl = 1'b1; sda_ctl = 1'b1;
    rst_n = 1'b0;
    wt(5);
    // R10 reset state
    chk("R10 scl_pull in reset", int'(scl_pull_o), 0);
    chk("R10 sda_pull in reset", int'(sda_pull_o), 0);
    rst_n = 1'b1;
    wt(10);
    chk("R10 rx_valid after reset", int'(rx_valid_o), 0);
    chk("R10 tx_ready after reset", int'(tx_ready_o), 0);

    // vector table
    for (int i = 0; i < 8; i++) begin
      v = VECS[i];
      rx_dly = int'(v.dly); tx_dly = int'(v.dly);
      rx0 = rx_n; tx0 = tx_n;
      tx_mem[tx0[5:0]] = v.data;
      pull_cnt = 0;
      bus_start();
      wr_byte({v.addr, v.rw}, a);
      chk(v.hit ? "R2 address ack" : "R3 mismatch no ack", int'(a), v.hit ? 0 : 1);
      if (!v.rw) begin
        wr_byte(v.data, a2);
        if (v.hit) begin
          chk("R4 data ack", int'(a2), 0);
          chk("R4 data count", rx_n, rx0 + 1);
          chk("R4 data value", int'(rx_log[rx0[5:0]]), int'(v.data));
          chk_rng("R5 stretch length", pull_cnt, int'(v.dly) + 1, int'(v.dly) + 3);
        end else begin
          chk("R3 no data ack", int'(a2), 1);
          chk("R3 no rx_valid", rx_n, rx0);
        end
      end else begin
        rd_byte(d, 1'b1);
        if (v.hit) begin
          chk("R6 read value", int'(d), int'(v.data));
          chk("R6 one request", tx_n, tx0 + 1);
          chk_rng("R6 stretch length", pull_cnt, int'(v.dly) + 1, int'(v.dly) + 3);
        end else begin
          chk("R3 released bus reads ones", int'(d), 8'hFF);
          chk("R3 no tx_ready", tx_n, tx0);
        end
      end
      bus_stop();
    end

    // multi-byte write with stretch
    rx_dly = 25; rx0 = rx_n; pull_cnt = 0;
    bus_start();
    wr_byte({OWN, 1'b0}, a);
    for (int k = 0; k < 3; k++) begin
      wr_byte(8'h30 + 8'(k * 17), a2);
      chk("R4 multi ack", int'(a2), 0);
    end
    bus_stop();
    for (int k = 0; k < 3; k++)
      chk("R4 multi value", int'(rx_log[6'(rx0 + k)]), 8'h30 + k * 17);
    chk_rng("R5 multi stretch", pull_cnt, 3 * 25 + 3, 3 * 25 + 9);

    // multi-byte read, ACK ACK NACK, then one idle clock
    tx_dly = 7; tx0 = tx_n;
    tx_mem[6'(tx0)] = 8'h5A; tx_mem[6'(tx0 + 1)] = 8'hE1; tx_mem[6'(tx0 + 2)] = 8'h0F;
    bus_start();
    wr_byte({OWN, 1'b1}, a);
    rd_byte(d, 1'b0); chk("R6 read byte 0", int'(d), 8'h5A);
    rd_byte(d, 1'b0); chk("R6 read byte 1", int'(d), 8'hE1);
    rd_byte(d, 1'b1); chk("R6 read byte 2", int'(d), 8'h0F);
    recv_bit(b);
    chk("R7 SDA released after NACK", int'(b), 1);
    wt(20);
    chk("R7 no request after NACK", tx_n, tx0 + 3);
    bus_stop();

    // repeated START from write into read
    rx_dly = 2; tx_dly = 2; rx0 = rx_n; tx0 = tx_n;
    tx_mem[6'(tx0)] = 8'h66;
    bus_start();
    wr_byte({OWN, 1'b0}, a);
    wr_byte(8'h5C, a2);
    chk("R4 before restart", int'(rx_log[6'(rx0)]), 8'h5C);
    bus_rstart();
    wr_byte({OWN, 1'b1}, a);
    chk("R8 restart address ack", int'(a), 0);
    rd_byte(d, 1'b1);
    chk("R8 read after restart", int'(d), 8'h66);
    bus_stop();

    // repeated START after a mismatch
    rx0 = rx_n;
    bus_start();
    wr_byte({7'h11, 1'b0}, a);
    chk("R3 foreign address", int'(a), 1);
    bus_rstart();
    wr_byte({OWN, 1'b0}, a);
    chk("R8 ack after mismatch restart", int'(a), 0);
    wr_byte(8'hB4, a2);
    chk("R8 data after restart", int'(rx_log[6'(rx0)]), 8'hB4);
    bus_stop();

    // STOP in the middle of a byte, then clocks with no START
    rx0 = rx_n;
    bus_start();
    wr_byte({OWN, 1'b0}, a);
    for (int k = 0; k < 4; k++) send_bit(1'b1);
    bus_stop();
    chk("R1 lines released after STOP", int'(scl_pull_o | sda_pull_o), 0);
    scl_ctl = 1'b0; wt(Q);
    wr_byte(8'h3C, a2);
    chk("R1 no ack while idle", int'(a2), 1);
    chk("R1 no byte while idle", rx_n, rx0);
    bus_stop();

    chk("R9 SDA changes with SCL low", sda_viol, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule